// File: doc/BRIEF.md
# Display Self-Test Sequencer

This block runs the built-in self test of a small dot-matrix character display controller. A start request, which stands for software setting the self-test bit of the control word, launches a run of fixed length. While it runs, the block owns the controller: it keeps `busy` high, steps the internal character-decoder ROM through every address while adding up the words it returns, and puts a checkerboard and then the inverse checkerboard onto the LED pattern-override bus.

The run lasts exactly 2^(HALF_LOG+1) clocks, which is 262,144 clocks at the default setting. Each pattern holds for one half of that time. The ROM sweep fits inside the first half. When the run ends, the block compares the modulo-2^16 sum of the ROM words with an expected constant. It publishes the result on the read-only `pass` bit. It also fires one-cycle strobes that blank the character RAM, clear the flash RAM, set the user-character address register to all ones and clear every control-word bit except the result bit.

A reset during a run aborts it. The pass bit then reads zero and no completion strobes are issued.

Top module: `disp_selftest`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block leaves that edge with `busy`, `pass`, `pat_en` and all four strobes at 0, and with `rom_addr` and `pat_bits` at 0.
- R2: A `start_req` sampled high while idle makes `busy` read 1 from the next cycle on, for exactly 2^(HALF_LOG+1) consecutive cycles.
- R3: A `start_req` sampled while `busy` is high is ignored. The run's length, its address sweep and its pattern timing do not change.
- R4: In busy cycle k, counted from 0, `rom_addr` equals k for k < 2^ROM_AW, and equals 0 after that and whenever the block is idle.
- R5: The ROM word at address a is (29·a + 7) mod 2^ROM_DW. `pass` is cleared when a run starts and reads 0 while busy. In the first idle cycle after a completed run, `pass` becomes 1 if and only if the sum of all ROM words, taken mod 2^16, equals `EXP_SUM`. It then holds that value until the next start or reset.
- R6: While busy, `pat_en` is 1. Bit r·COLS+c of `pat_bits` (row r, column c) is 1 exactly when r+c is even during the first 2^HALF_LOG busy cycles, and is the inverse of that during the remaining cycles. When idle, `pat_en` and `pat_bits` are 0.
- R7: `clr_char`, `clr_flash`, `udc_ones` and `ctl_clr` pulse high together for one cycle, in the first cycle in which `busy` reads 0 after a completed run, and at no other time.
- R8: A reset during a run ends it. After the reset edge, `busy` and `pass` read 0, and no completion strobe follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request to launch the self test |
| rom_addr | output | ROM_AW | Address driven into the character-decoder ROM |
| pat_en | output | 1 | Pattern override active |
| pat_bits | output | COLS*ROWS | Dot pattern, bit r*COLS+c for row r, column c |
| busy | output | 1 | Test in progress; host must not access the display |
| pass | output | 1 | Read-only test result, 1 = pass |
| clr_char | output | 1 | Strobe: fill character RAM with blanks |
| clr_flash | output | 1 | Strobe: clear flash RAM |
| udc_ones | output | 1 | Strobe: set user-character address register to all ones |
| ctl_clr | output | 1 | Strobe: clear control word except the result bit |

## Verification
Every result is one register away from the start edge. `busy`, address 0 and the first checkerboard appear in the cycle after `start_req` is sampled. Each further address and the pattern flip follow one cycle per count. The strobes and the new `pass` value appear together, exactly 2^(HALF_LOG+1) cycles after the first busy cycle. The driver pushes one expected item per cycle, starting from the start edge. The monitor pops them one cycle apart, one time unit after each rising edge, so every comparison lands on the cycle the count predicts. A second instance with a wrong expected sum covers the fail case. A mid-run start and a mid-run reset cover the ignore and abort cases.

// File: rtl/disp_st_pkg.sv
// Package: shared constants and constant functions for the display self-test.
// Assumes ROM word widths below 32 bits.
package disp_st_pkg;

    localparam int SUM_W = 16;

    // Content of the character-decoder ROM at address a, dw bits wide.
    function automatic logic [31:0] rom_word(input int unsigned a, input int unsigned dw);
        logic [31:0] v;
        v = 32'(a) * 32'd29 + 32'd7;
        return v & ((32'd1 << dw) - 32'd1);
    endfunction

    // Modulo-2^16 sum of the whole ROM, used as the default expected value.
    function automatic logic [SUM_W-1:0] rom_sum(input int unsigned depth, input int unsigned dw);
        logic [SUM_W-1:0] s;
        s = '0;
        for (int unsigned a = 0; a < depth; a++) begin
            s = s + SUM_W'(rom_word(a, dw));
        end
        return s;
    endfunction

endpackage

// File: rtl/disp_st_seq.sv
// Module: run sequencer. Accepts a start while idle, counts a fixed run of
// 2^(HALF_LOG+1) cycles and flags the last cycle and the completion cycle.
// Assumes start requests during a run are to be ignored.
module disp_st_seq #(
    parameter int HALF_LOG = 17,
    localparam int CNT_W = HALF_LOG + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output logic             accept,
    output logic             finish,
    output logic             done
);

    localparam logic [CNT_W-1:0] LAST = '1;

    // Start is honoured only while idle; finish marks the last busy cycle.
    always_comb begin
        accept = start_req && !busy;
        finish = busy && (cnt == LAST);
    end

    // Run state, cycle counter and one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (finish) begin
                busy <= 1'b0;
                cnt  <= '0;
                done <= 1'b1;
            end else if (busy) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/disp_st_rom.sv
// Module: character-decoder ROM, computed per address so no table is stored.
// Assumes DW < 32.
module disp_st_rom #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    import disp_st_pkg::*;

    // Combinational lookup.
    always_comb data = DW'(rom_word(32'(addr), DW));

endmodule

// File: rtl/disp_st_sum.sv
// Module: modulo-2^16 checksum accumulator with a compare against a constant.
// Assumes clear and accumulate are never requested in the same cycle.
module disp_st_sum #(
    parameter int DW = 8,
    parameter logic [disp_st_pkg::SUM_W-1:0] EXP = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          acc_en,
    input  logic [DW-1:0] data,
    output logic          match
);
    import disp_st_pkg::*;

    logic [SUM_W-1:0] sum;

    // Running sum, cleared when a run is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) sum <= '0;
        else if (acc_en)     sum <= sum + SUM_W'(data);
    end

    // Compare the running sum with the expected value.
    always_comb match = (sum == EXP);

endmodule

// File: rtl/disp_st_pat.sv
// Module: checkerboard generator. A dot at row r, column c is lit when r+c is
// even in phase 0, and the pattern is inverted in phase 1. Output is 0 when idle.
module disp_st_pat #(
    parameter int COLS = 5,
    parameter int ROWS = 7,
    localparam int PW = COLS * ROWS
) (
    input  logic          en,
    input  logic          phase,
    output logic [PW-1:0] bits
);

    logic [PW-1:0] base;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign base[r*COLS+c] = ((r + c) % 2 == 0);
        end
    end

    // Select the plain or inverse pattern, forced to 0 when idle.
    always_comb bits = en ? (phase ? ~base : base) : '0;

endmodule

// File: rtl/disp_selftest.sv
// Module: display self-test sequencer top. It sweeps the decoder ROM and sums
// it, shows two checkerboard phases, then reports the result and issues the
// re-initialisation strobes. Assumes ROM_AW <= HALF_LOG and ROM_DW < 32.
module disp_selftest #(
    parameter int ROM_AW   = 7,
    parameter int ROM_DW   = 8,
    parameter int HALF_LOG = 17,
    parameter int COLS     = 5,
    parameter int ROWS     = 7,
    parameter logic [disp_st_pkg::SUM_W-1:0] EXP_SUM =
        disp_st_pkg::rom_sum(2 ** ROM_AW, ROM_DW),
    localparam int PW    = COLS * ROWS,
    localparam int CNT_W = HALF_LOG + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              pat_en,
    output logic [PW-1:0]     pat_bits,
    output logic              busy,
    output logic              pass,
    output logic              clr_char,
    output logic              clr_flash,
    output logic              udc_ones,
    output logic              ctl_clr
);

    localparam logic [CNT_W-1:0] DEPTH = CNT_W'(2 ** ROM_AW);

    logic [CNT_W-1:0]  cnt;
    logic              accept, finish, done, in_rom, match;
    logic [ROM_DW-1:0] rom_q;

    disp_st_seq #(.HALF_LOG(HALF_LOG)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .busy(busy), .cnt(cnt), .accept(accept), .finish(finish), .done(done)
    );

    // ROM sweep window: the first 2^ROM_AW busy cycles.
    always_comb begin
        in_rom   = busy && (cnt < DEPTH);
        rom_addr = in_rom ? cnt[ROM_AW-1:0] : '0;
    end

    disp_st_rom #(.AW(ROM_AW), .DW(ROM_DW)) u_rom (
        .addr(rom_addr), .data(rom_q)
    );

    disp_st_sum #(.DW(ROM_DW), .EXP(EXP_SUM)) u_sum (
        .clk(clk), .rst_n(rst_n), .clear(accept), .acc_en(in_rom),
        .data(rom_q), .match(match)
    );

    disp_st_pat #(.COLS(COLS), .ROWS(ROWS)) u_pat (
        .en(busy), .phase(cnt[HALF_LOG]), .bits(pat_bits)
    );

    // Result bit: cleared on start, loaded on the last busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) pass <= 1'b0;
        else if (finish)      pass <= match;
    end

    // Pattern override and completion strobes.
    always_comb begin
        pat_en    = busy;
        clr_char  = done;
        clr_flash = done;
        udc_ones  = done;
        ctl_clr   = done;
    end

endmodule

// File: rtl/disp_selftest_chk.sv
// Module: protocol checker for disp_selftest, bound to every instance.
module disp_selftest_chk #(
    parameter int AW = 7,
    parameter int PW = 35
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          pass,
    input logic [AW-1:0] rom_addr,
    input logic          pat_en,
    input logic [PW-1:0] pat_bits,
    input logic          udc_ones,
    input logic          clr_flash
);

    // R4
    addr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> rom_addr == '0);

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && rom_addr != '0 |-> rom_addr == $past(rom_addr) + 1'b1);

    // R5
    pass_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !pass);

    // R6
    pat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pat_en |-> pat_bits == '0);

    // R6
    pat_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && pat_bits != $past(pat_bits) |-> pat_bits == ~$past(pat_bits));

    // R7
    strobe_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && $past(rst_n) |-> udc_ones);

    // R7
    strobe_only_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_flash |-> !busy && $past(busy));

endmodule

bind disp_selftest disp_selftest_chk #(.AW(ROM_AW), .PW(COLS * ROWS)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .pass(pass), .rom_addr(rom_addr),
    .pat_en(pat_en), .pat_bits(pat_bits), .udc_ones(udc_ones), .clr_flash(clr_flash)
);

// File: tb/disp_selftest_bench.sv
// Scoreboard bench: the driver queues one expected item per cycle of a run and
// the monitor compares them one time unit after each rising edge.
module disp_selftest_bench;

    localparam int AW = 5, DW = 8, HL = 6, COLS = 5, ROWS = 7;
    localparam int PW = COLS * ROWS;
    localparam int HALF = 1 << HL, TOTAL = 2 * HALF, DEPTH = 1 << AW;

    function automatic logic [15:0] ref_sum();
        logic [15:0] s = '0;
        for (int a = 0; a < DEPTH; a++) s = s + 16'(((a * 29) + 7) % 256);
        return s;
    endfunction

    function automatic logic [PW-1:0] ref_chk();
        logic [PW-1:0] b;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                b[r*COLS+c] = ((r + c) % 2 == 0);
        return b;
    endfunction

    localparam logic [15:0] GOOD = ref_sum();
    localparam logic [15:0] BAD  = GOOD ^ 16'h0001;
    localparam logic [PW-1:0] CHK = ref_chk();

    logic clk = 1'b0, rst_n = 1'b0, start_req = 1'b0;
    logic [AW-1:0] rom_addr, b_addr;
    logic [PW-1:0] pat_bits, b_bits;
    logic pat_en, busy, pass, clr_char, clr_flash, udc_ones, ctl_clr;
    logic b_pen, b_busy, b_pass, b_c0, b_c1, b_c2, b_c3;

    always #2 clk = ~clk;

    disp_selftest #(.ROM_AW(AW), .ROM_DW(DW), .HALF_LOG(HL), .COLS(COLS), .ROWS(ROWS),
                    .EXP_SUM(GOOD)) u_disp_selftest (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .rom_addr(rom_addr),
        .pat_en(pat_en), .pat_bits(pat_bits), .busy(busy), .pass(pass),
        .clr_char(clr_char), .clr_flash(clr_flash), .udc_ones(udc_ones), .ctl_clr(ctl_clr));

    disp_selftest #(.ROM_AW(AW), .ROM_DW(DW), .HALF_LOG(HL), .COLS(COLS), .ROWS(ROWS),
                    .EXP_SUM(BAD)) u_bad (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .rom_addr(b_addr),
        .pat_en(b_pen), .pat_bits(b_bits), .busy(b_busy), .pass(b_pass),
        .clr_char(b_c0), .clr_flash(b_c1), .udc_ones(b_c2), .ctl_clr(b_c3));

    typedef struct {
        logic          busy;
        logic [AW-1:0] addr;
        logic          pen;
        logic [PW-1:0] bits;
        logic          strb;
        logic          pass;
        string         ctx;
    } exp_t;

    exp_t q[$];
    exp_t me;
    int   n_run = 0, n_fail = 0;
    bit   ended = 1'b0;

    task automatic check(input bit ok, input string req, input string ctx,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, ctx, act, exp);
        end
    endtask

    function automatic logic [3:0] strobes();
        return {clr_char, clr_flash, udc_ones, ctl_clr};
    endfunction

    // Monitor: compare one queued item per cycle, away from the edge.
    always begin
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            me = q.pop_front();
            check(busy == me.busy, "R2", me.ctx, 64'(busy), 64'(me.busy));
            check(rom_addr == me.addr, "R4", me.ctx, 64'(rom_addr), 64'(me.addr));
            check(pat_en == me.pen && pat_bits == me.bits, "R6", me.ctx,
                  64'(pat_bits), 64'(me.bits));
            check(strobes() == {4{me.strb}}, "R7", me.ctx, 64'(strobes()), 64'({4{me.strb}}));
            check(pass == me.pass, "R5", me.ctx, 64'(pass), 64'(me.pass));
            check(b_pass == 1'b0, "R5 bad-sum", me.ctx, 64'(b_pass), 64'd0);
        end
    end

    // Driver: launch a run, queue its expected items, optionally restart mid-run (R3).
    task automatic launch(input bit mid, input string ctx);
        exp_t e;
        @(negedge clk);
        start_req = 1'b1;
        for (int k = 0; k < TOTAL + 2; k++) begin
            e.busy = (k < TOTAL);
            e.addr = (k < DEPTH) ? AW'(k) : '0;
            e.pen  = (k < TOTAL);
            e.bits = (k < HALF) ? CHK : (k < TOTAL) ? ~CHK : '0;
            e.strb = (k == TOTAL);
            e.pass = (k >= TOTAL);
            e.ctx  = ctx;
            q.push_back(e);
        end
        @(negedge clk);
        start_req = 1'b0;
        if (mid) begin
            repeat (HALF - 3) @(negedge clk);
            start_req = 1'b1;
            @(negedge clk);
            start_req = 1'b0;
        end
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        bit strobe_seen;
        repeat (3) @(negedge clk);
        // R1: state while in reset
        check(busy == 0 && pass == 0 && pat_en == 0 && strobes() == 0,
              "R1", "reset flags", 64'({busy, pass, pat_en, strobes()}), 64'd0);
        check(rom_addr == 0 && pat_bits == 0, "R1", "reset buses",
              64'(pat_bits), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        launch(1'b0, "first run");
        launch(1'b1, "R3 restart mid-run ignored");

        // R5: result held while idle
        repeat (5) @(negedge clk);
        check(pass == 1'b1, "R5", "pass held", 64'(pass), 64'd1);

        // R8: reset during a run aborts it
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        repeat (15) @(negedge clk);
        check(busy == 1'b1, "R8", "running before abort", 64'(busy), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(busy == 1'b0 && pass == 1'b0 && pat_en == 1'b0, "R8", "after abort",
              64'({busy, pass, pat_en}), 64'd0);
        strobe_seen = 1'b0;
        for (int i = 0; i < TOTAL + 4; i++) begin
            @(negedge clk);
            if (strobes() != 0) strobe_seen = 1'b1;
        end
        check(!strobe_seen, "R8", "no strobe after abort", 64'(strobe_seen), 64'd0);

        launch(1'b0, "run after abort");
        ended = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule